// File: doc/BRIEF.md
# Converter Start-up and Protection Sequencer

This block supervises the power stage of a digitally controlled switching converter. It decides, every clock, whether the stage is held off, is pumped by a free-running start-up oscillator on the low-side switch, or is handed to the main regulation controller. It sees five asynchronous comparator and pin flags: supply present, output high enough for regulation, output below the lockout level, over-temperature and shutdown. It also sees the regulation controller's own mode bit, which is synchronous and reports PWM (1) or PFM (0).

Each flag passes through a synchroniser and then a persistence filter. The filtered flags drive a four-state machine. A loss of regulation headroom drops the stage back to oscillator start-up. A deeper fall below the lockout level stops all switching. Over-temperature halts switching only while the controller runs in PWM, and the halt clears by itself.

Top module: `cvseq_top`

## Requirements
- R1: When shutdown is asserted, all three drive outputs turn off 3 clocks after the input changes (`switch_off_o`=1, the others 0). The state becomes OFF one clock later, from any state.
- R2: After reset the state is OFF (status 0) and `switch_off_o` is 1, with `ctrl_enable_o` and `startup_gate_o` at 0.
- R3: From OFF, with supply present, no lockout and no shutdown, the state becomes STARTUP (status 1). STARTUP is the only state in which `startup_gate_o` is 1.
- R4: From STARTUP, once the output is high enough for regulation, the state becomes REGULATE (status 2). REGULATE is the only state in which `ctrl_enable_o` is 1.
- R5: In REGULATE, loss of the regulation-level flag returns the state to STARTUP.
- R6: Output below lockout sends every state to OFF. OFF is held while the lockout flag stays set.
- R7: In REGULATE with the mode input at 1 (PWM), over-temperature moves the state to THERMAL_STOP (status 3), which turns off both the controller and the start-up gate. With the mode input at 0 (PFM), over-temperature has no effect.
- R8: When over-temperature clears in THERMAL_STOP, the state moves to REGULATE if the regulation-level flag is set, and to STARTUP otherwise.
- R9: Every flag other than an asserting shutdown changes the state exactly 7 clocks after its input changes: 2 synchroniser stages, 4 stable cycles, then 1 state register. A level held for 3 or fewer clocks is ignored.
- R10: Releasing shutdown always passes through STARTUP. The state never goes from OFF to REGULATE in one step.
- R11: The status output encodes OFF=0, STARTUP=1, REGULATE=2, THERMAL_STOP=3.
- R12: In STARTUP, loss of the supply-present flag returns the state to OFF.
- R13: Exactly one of `ctrl_enable_o`, `startup_gate_o` and `switch_off_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Async: supply pin above start threshold |
| out_reg_ok_i | input | 1 | Async: output high enough for regulation |
| out_lockout_i | input | 1 | Async: output below lockout level |
| over_temp_i | input | 1 | Async: die over-temperature |
| shutdown_i | input | 1 | Async: shutdown pin, 1 = off |
| pwm_mode_i | input | 1 | Sync: controller mode, 1 = PWM, 0 = PFM |
| ctrl_enable_o | output | 1 | Enable for the regulation controller |
| startup_gate_o | output | 1 | Gate enable from start-up oscillator to low-side switch |
| switch_off_o | output | 1 | Global disable of both switches |
| state_o | output | 2 | Current state code |

## Verification
The hardest conditions to reach are those that need two flags in a precise order. One is an over-temperature that is already filtered high while the mode is PFM, followed by a switch to PWM. Another is a THERMAL_STOP state in which the regulation flag is lost before the temperature clears. The stimulus sets one flag at a time and waits exactly the 7-clock filter latency before the next. Thermal is first held through a PFM period and then exposed by flipping the unfiltered mode bit. A 3-cycle pulse and a 6-clock early sample mark the edges of the persistence window.

// File: rtl/cvseq_pkg.sv
package cvseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_STARTUP  = 2'd1,
        ST_REGULATE = 2'd2,
        ST_THERMAL  = 2'd3
    } seq_state_e;

    localparam int FLAG_COUNT  = 5;
    localparam int FLG_SUPPLY  = 0;
    localparam int FLG_REGOK   = 1;
    localparam int FLG_LOCKOUT = 2;
    localparam int FLG_HOT     = 3;
    localparam int FLG_SHDN    = 4;

    typedef struct packed {
        logic shdn;
        logic hot;
        logic lockout;
        logic regok;
        logic supply;
    } flag_set_t;

endpackage

// File: rtl/cvseq_flag_filter.sv
module cvseq_flag_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4,
    parameter bit FAST_ASSERT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic [CW-1:0]          cnt;
        logic                   filt;
    } flt_t;

    flt_t flt_d, flt_q;
    logic synced;
    logic take_now;

    assign synced = flt_q.chain[SYNC_STAGES-1];

    // A parameter picks whether an asserting level bypasses the persistence count
    generate
        if (FAST_ASSERT) begin : g_fast
            assign take_now = synced & ~flt_q.filt;
        end else begin : g_slow
            assign take_now = 1'b0;
        end
    endgenerate

    always_comb begin
        flt_d       = flt_q;
        flt_d.chain = {flt_q.chain[SYNC_STAGES-2:0], raw_i};
        if (synced != flt_q.filt) begin
            if (take_now || flt_q.cnt == LAST) begin
                flt_d.filt = synced;
                flt_d.cnt  = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign filt_o = flt_q.filt;

    // R9: a filtered change only ever adopts the level the synchroniser held
    a_r9_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.filt != $past(flt_q.filt)) |-> ($past(synced) == flt_q.filt));

    // R9: the persistence counter never runs past its window
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q.cnt <= LAST);

endmodule

// File: rtl/cvseq_fsm.sv
module cvseq_fsm
    import cvseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  flag_set_t  flg_i,
    input  logic       pwm_mode_i,
    output seq_state_e state_o,
    output logic       ctrl_enable_o,
    output logic       startup_gate_o,
    output logic       switch_off_o
);
    typedef struct packed {
        seq_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (flg_i.shdn) begin
            fsm_d.st = ST_OFF;
        end else begin
            unique case (fsm_q.st)
                ST_OFF: begin
                    if (flg_i.supply && !flg_i.lockout) fsm_d.st = ST_STARTUP;
                end
                ST_STARTUP: begin
                    if (flg_i.lockout || !flg_i.supply) fsm_d.st = ST_OFF;
                    else if (flg_i.regok)               fsm_d.st = ST_REGULATE;
                end
                ST_REGULATE: begin
                    if (flg_i.lockout)                fsm_d.st = ST_OFF;
                    else if (!flg_i.regok)            fsm_d.st = ST_STARTUP;
                    else if (flg_i.hot && pwm_mode_i) fsm_d.st = ST_THERMAL;
                end
                ST_THERMAL: begin
                    if (flg_i.lockout)   fsm_d.st = ST_OFF;
                    else if (!flg_i.hot) fsm_d.st = flg_i.regok ? ST_REGULATE : ST_STARTUP;
                end
                default: fsm_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_OFF};
        else        fsm_q <= fsm_d;
    end

    assign state_o        = fsm_q.st;
    assign ctrl_enable_o  = (fsm_q.st == ST_REGULATE) && !flg_i.shdn;
    assign startup_gate_o = (fsm_q.st == ST_STARTUP)  && !flg_i.shdn;
    assign switch_off_o   = (fsm_q.st == ST_OFF) || (fsm_q.st == ST_THERMAL) || flg_i.shdn;

    a_r1_shdn_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        flg_i.shdn |=> (fsm_q.st == ST_OFF));

    a_r6_lockout_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        flg_i.lockout |=> (fsm_q.st == ST_OFF));

    a_r10_no_off_to_regulate: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_OFF) |=> (fsm_q.st != ST_REGULATE));

    a_r7_pwm_hot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_REGULATE && flg_i.hot && pwm_mode_i && flg_i.regok
         && !flg_i.lockout && !flg_i.shdn) |=> (fsm_q.st == ST_THERMAL));

    a_r8_thermal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_THERMAL && !flg_i.hot) |=> (fsm_q.st != ST_THERMAL));

    a_r13_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({ctrl_enable_o, startup_gate_o, switch_off_o}));

endmodule

// File: rtl/cvseq_top.sv
module cvseq_top
    import cvseq_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       out_reg_ok_i,
    input  logic       out_lockout_i,
    input  logic       over_temp_i,
    input  logic       shutdown_i,
    input  logic       pwm_mode_i,
    output logic       ctrl_enable_o,
    output logic       startup_gate_o,
    output logic       switch_off_o,
    output logic [1:0] state_o
);
    logic [FLAG_COUNT-1:0] raw_flags;
    logic [FLAG_COUNT-1:0] filt_flags;
    flag_set_t             flg;
    seq_state_e            st;

    always_comb begin
        raw_flags              = '0;
        raw_flags[FLG_SUPPLY]  = supply_ok_i;
        raw_flags[FLG_REGOK]   = out_reg_ok_i;
        raw_flags[FLG_LOCKOUT] = out_lockout_i;
        raw_flags[FLG_HOT]     = over_temp_i;
        raw_flags[FLG_SHDN]    = shutdown_i;
    end

    generate
        for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_flag
            cvseq_flag_filter #(
                .SYNC_STAGES  (SYNC_STAGES),
                .STABLE_CYCLES(STABLE_CYCLES),
                .FAST_ASSERT  (g == FLG_SHDN)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .raw_i (raw_flags[g]),
                .filt_o(filt_flags[g])
            );
        end
    endgenerate

    always_comb begin
        flg.supply  = filt_flags[FLG_SUPPLY];
        flg.regok   = filt_flags[FLG_REGOK];
        flg.lockout = filt_flags[FLG_LOCKOUT];
        flg.hot     = filt_flags[FLG_HOT];
        flg.shdn    = filt_flags[FLG_SHDN];
    end

    cvseq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .flg_i         (flg),
        .pwm_mode_i    (pwm_mode_i),
        .state_o       (st),
        .ctrl_enable_o (ctrl_enable_o),
        .startup_gate_o(startup_gate_o),
        .switch_off_o  (switch_off_o)
    );

    assign state_o = st;

endmodule

// File: tb/cvseq_top_tb.sv
`timescale 1ns/1ps
module cvseq_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0, reg_ok = 1'b0, lockout = 1'b0, hot = 1'b0, shdn = 1'b0;
    logic       pwm = 1'b1;
    logic       ce, sg, so;
    logic [1:0] st;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    typedef struct {
        logic [1:0] st;
        logic       ce;
        logic       sg;
        logic       so;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #10 clk = ~clk;

    cvseq_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok_i   (supply_ok),
        .out_reg_ok_i  (reg_ok),
        .out_lockout_i (lockout),
        .over_temp_i   (hot),
        .shutdown_i    (shdn),
        .pwm_mode_i    (pwm),
        .ctrl_enable_o (ce),
        .startup_gate_o(sg),
        .switch_off_o  (so),
        .state_o       (st)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_raw(logic [1:0] s, logic c, logic g, logic o, string tag);
        exp_t e;
        e.st = s; e.ce = c; e.sg = g; e.so = o; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // R11: state codes 0..3; R13: output drive follows the state code
    task automatic expect_state(logic [1:0] s, string tag);
        expect_raw(s, s == 2'd2, s == 2'd1, (s == 2'd0) || (s == 2'd3), tag);
    endtask

    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (st !== e.st || ce !== e.ce || sg !== e.sg || so !== e.so) begin
                    bad++;
                    $display("FAIL %s: got st=%0d ce=%0b sg=%0b so=%0b, want st=%0d ce=%0b sg=%0b so=%0b",
                             e.tag, st, ce, sg, so, e.st, e.ce, e.sg, e.so);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running, want finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_state(2'd0, "R2 reset OFF");

        supply_ok = 1'b1;
        tick(6);
        expect_state(2'd0, "R9 not yet after 6 clocks");
        tick(1);
        expect_state(2'd1, "R3 OFF to STARTUP");

        reg_ok = 1'b1;
        tick(3);
        reg_ok = 1'b0;
        tick(12);
        expect_state(2'd1, "R9 3-cycle pulse ignored");

        reg_ok = 1'b1;
        tick(7);
        expect_state(2'd2, "R4 STARTUP to REGULATE");

        pwm = 1'b0;
        hot = 1'b1;
        tick(10);
        expect_state(2'd2, "R7 hot ignored in PFM");

        pwm = 1'b1;
        tick(1);
        expect_state(2'd3, "R7 hot in PWM stops");

        hot = 1'b0;
        tick(7);
        expect_state(2'd2, "R8 thermal clears to REGULATE");

        reg_ok = 1'b0;
        tick(7);
        expect_state(2'd1, "R5 regulation lost");

        supply_ok = 1'b0;
        tick(7);
        expect_state(2'd0, "R12 supply lost");

        supply_ok = 1'b1;
        tick(7);
        expect_state(2'd1, "R3 restart");
        reg_ok = 1'b1;
        tick(7);
        expect_state(2'd2, "R4 regulate again");

        shdn = 1'b1;
        tick(3);
        expect_raw(2'd2, 1'b0, 1'b0, 1'b1, "R1 drives off before state");
        tick(1);
        expect_state(2'd0, "R1 shutdown OFF");

        shdn = 1'b0;
        tick(7);
        expect_state(2'd1, "R10 release enters STARTUP");
        tick(1);
        expect_state(2'd2, "R10 then REGULATE");

        lockout = 1'b1;
        tick(7);
        expect_state(2'd0, "R6 lockout OFF");
        tick(10);
        expect_state(2'd0, "R6 OFF held during lockout");

        lockout = 1'b0;
        tick(7);
        expect_state(2'd1, "R3 after lockout");
        tick(1);
        expect_state(2'd2, "R4 after lockout");

        hot = 1'b1;
        tick(7);
        expect_state(2'd3, "R7 thermal again");
        reg_ok = 1'b0;
        tick(10);
        expect_state(2'd3, "R8 held while hot");
        hot = 1'b0;
        tick(7);
        expect_state(2'd1, "R8 clears to STARTUP");

        tick(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule